// File: doc/BRIEF.md
# Floppy Controller Host-Interface Sequencer

This block is the processor side of a floppy disk controller. The processor sees two things. One is a status byte that it may read at any time. The other is a data port that it uses to write command bytes and to read result bytes. Each command passes through up to three phases: command, execution and result. The sequencer counts the bytes of each phase from a table indexed by the opcode. It moves from one phase to the next without any extra request. Every data-port access is gated by the handshake bits in the status byte.

The execution phase is a stub. It lasts `EXEC_CYCLES` cycles, or ends earlier when `exec_done` pulses. Data commands then move `XFER_BYTES` bytes. In non-DMA mode each byte raises the interrupt and waits for a processor access. In DMA mode each byte raises a DMA request that waits for the acknowledge. Disk media access, data separation and seek mechanics are not part of the block.

The control FSM has four phases. IDLE waits for an opcode. CMD collects parameters. EXEC runs the stub. RESULT presents the result bytes. Its transitions are as follows:

- IDLE to CMD when an opcode with parameters is accepted.
- IDLE or CMD to EXEC, RESULT or IDLE after the last command byte. The target is EXEC if the command executes, otherwise RESULT if it returns bytes, otherwise IDLE.
- EXEC to RESULT when the stub signals completion.
- RESULT to IDLE after the last result byte is read.

The stub has its own FSM: OFF, DELAY, XFER (byte ready) and GAP (one idle cycle between bytes).

Top module: `fdc_host_seq`

## Requirements
- R1: The status byte `msr` is laid out as follows: bit 7 = ready-for-host, bit 6 = direction (1 = controller to processor), bit 5 = non-DMA execution, bit 4 = busy, bits 3..0 = `seek_busy`. After reset it reads `{4'h8, seek_busy}`.
- R2: A data-port write is accepted only while bit 7 is 1 and bit 6 is 0. Any other write leaves the phase and the byte count unchanged.
- R3: A data-port read is accepted only while bits 7 and 6 are both 1. Any other read leaves the phase and the byte count unchanged.
- R4: The opcode's bits 4..0 select the (parameter, result) counts, and bits 7..5 are ignored:
  - 0x06 read data: (8, 7), executes and moves bytes to the processor.
  - 0x05 write data: (8, 7), executes and moves bytes from the processor.
  - 0x0F seek: (2, 1), executes without data.
  - 0x03 specify: (2, 0).
  - 0x04 sense drive: (1, 1).
  - 0x08 sense interrupt: (0, 2).
- R5: Busy (bit 4) is 1 from the accepted opcode until the last result byte is read. While busy is 0, `msr` shows `{4'h8, seek_busy}`.
- R6: The execution phase keeps bit 7 at 0 for exactly `EXEC_CYCLES` cycles after the last command byte. A pulse on `exec_done` ends this delay at the next edge.
- R7: In non-DMA mode, bit 5 is 1 during the execution phase. When a byte is ready, `msr` shows bit 7 = 1 and bit 6 = that command's direction, and `irq` rises a cycle later. The accepting access clears `irq`. The byte read at index i is `8'hD0 + i`.
- R8: In DMA mode, `irq`, bit 7 and bit 5 stay 0 during the execution phase. `dreq` is 1 while a byte is ready and falls the cycle after `dack_n` is sampled low.
- R9: When the execution phase ends, `irq` rises together with the result phase. The first result read clears it. Commands that do not execute raise no `irq`.
- R10: Result byte k equals `opcode ^ (k << 5)`. Writes during the result phase are refused. After the last byte is read the block returns to idle.
- R11: Any opcode outside the table takes no parameters and returns the single result byte 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Data-port write strobe, one cycle per byte |
| rd_stb | input | 1 | Data-port read strobe, one cycle per byte |
| wdata | input | 8 | Byte written by the processor |
| rdata | output | 8 | Byte presented to the processor |
| msr | output | 8 | Status byte |
| dma_mode | input | 1 | Transfer mode, latched with the opcode (1 = DMA) |
| dreq | output | 1 | DMA request |
| dack_n | input | 1 | DMA acknowledge, active low |
| irq | output | 1 | Interrupt request |
| exec_done | input | 1 | Early completion pulse for the execution stub |
| seek_busy | input | 4 | Per-drive seek-busy flags shown in the status byte |

## Verification
The checker enforces the following on every cycle:
- the direction bit never appears without ready-for-host;
- ignored accesses leave the phase and count untouched;
- idle shows a writable status;
- the non-DMA bit implies busy;
- a DMA request never coexists with ready-for-host or the interrupt, and it drops after acknowledge;
- a result read leaves the interrupt clear.

Only the bench scenarios can show the following:
- each opcode's byte counts;
- the exact length of the execution delay and the early-done path;
- the transfer and result byte values;
- the refusal of new commands before the result phase is drained.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RESULT} phase_e;
    typedef enum logic [1:0] {EX_OFF, EX_DELAY, EX_XFER, EX_GAP} exec_e;

    typedef struct packed {
        logic [3:0] n_param;
        logic [2:0] n_result;
        logic       runs_exec;
        logic       moves_data;
        logic       to_host;
        logic       invalid;
    } cmd_info_t;

    localparam logic [7:0] INVALID_STATUS = 8'h80;
    localparam logic [7:0] XFER_TAG       = 8'hD0;

    // R4 / R11: per-opcode byte counts, keyed on opcode bits 4..0
    function automatic cmd_info_t lookup(input logic [4:0] code);
        cmd_info_t c;
        c = '{n_param: 4'd0, n_result: 3'd1, runs_exec: 1'b0,
              moves_data: 1'b0, to_host: 1'b0, invalid: 1'b1};
        case (code)
            5'h06: c = '{4'd8, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0};
            5'h05: c = '{4'd8, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0};
            5'h0F: c = '{4'd2, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0};
            5'h03: c = '{4'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0};
            5'h04: c = '{4'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0};
            5'h08: c = '{4'd0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0};
            default: ;
        endcase
        return c;
    endfunction

    // R5: where the block goes once the last command byte is in
    function automatic phase_e after_command(input cmd_info_t c);
        if (c.runs_exec)           return PH_EXEC;
        else if (c.n_result != 0) return PH_RESULT;
        else                       return PH_IDLE;
    endfunction

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
    import fdc_seq_pkg::*;
(
    input  logic [4:0] code,
    output cmd_info_t  info
);
    always_comb info = lookup(code);
endmodule

// File: rtl/fdc_exec_stub.sv
module fdc_exec_stub
    import fdc_seq_pkg::*;
#(
    parameter int EXEC_CYCLES = 16,
    parameter int XFER_BYTES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          moves_data,
    input  logic          ext_done,
    input  logic          take,
    output logic          byte_rdy,
    output logic [7:0]    byte_idx,
    output logic          done
);
    localparam int DW = $clog2(EXEC_CYCLES + 1);
    localparam int XW = $clog2(XFER_BYTES + 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(EXEC_CYCLES - 1);
    localparam logic [XW-1:0] IDX_LAST = XW'(XFER_BYTES - 1);

    exec_e          st_q, st_n;
    logic [DW-1:0]  dly_q, dly_n;
    logic [XW-1:0]  idx_q, idx_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= EX_OFF;
            dly_q <= '0;
            idx_q <= '0;
        end else begin
            st_q  <= st_n;
            dly_q <= dly_n;
            idx_q <= idx_n;
        end
    end

    // R6: delay, then (for data commands) one byte per accepted transfer
    always_comb begin
        st_n  = st_q;
        dly_n = dly_q;
        idx_n = idx_q;
        done  = 1'b0;
        unique case (st_q)
            EX_OFF: begin
                if (start) begin
                    st_n  = EX_DELAY;
                    dly_n = '0;
                    idx_n = '0;
                end
            end
            EX_DELAY: begin
                if (ext_done || dly_q == DLY_LAST) begin
                    if (moves_data) begin
                        st_n = EX_XFER;
                    end else begin
                        st_n = EX_OFF;
                        done = 1'b1;
                    end
                end else begin
                    dly_n = dly_q + 1'b1;
                end
            end
            EX_XFER: begin
                if (take) begin
                    if (idx_q == IDX_LAST) begin
                        st_n = EX_OFF;
                        done = 1'b1;
                    end else begin
                        st_n  = EX_GAP;
                        idx_n = idx_q + 1'b1;
                    end
                end
            end
            EX_GAP: st_n = EX_XFER;
        endcase
    end

    assign byte_rdy = (st_q == EX_XFER);
    assign byte_idx = 8'(idx_q);
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
    import fdc_seq_pkg::*;
#(
    parameter int EXEC_CYCLES = 16,
    parameter int XFER_BYTES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] msr,
    input  logic       dma_mode,
    output logic       dreq,
    input  logic       dack_n,
    output logic       irq,
    input  logic       exec_done,
    input  logic [3:0] seek_busy
);
    localparam int CW = 4;

    phase_e         phase_q, phase_n;
    logic [7:0]     opcode_q, opcode_n;
    cmd_info_t      info_q, info_n, info_now;
    logic [CW-1:0]  cnt_q, cnt_n;
    logic           irq_q, irq_n;
    logic           dma_q, dma_n;

    logic rqm, dio, ndm, busy;
    logic wr_ok, rd_ok, take, exec_start, exec_fin, byte_rdy;
    logic [7:0] byte_idx;

    fdc_cmd_decode u_dec (
        .code (wdata[4:0]),
        .info (info_now)
    );

    fdc_exec_stub #(
        .EXEC_CYCLES (EXEC_CYCLES),
        .XFER_BYTES  (XFER_BYTES)
    ) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (exec_start),
        .moves_data (info_q.moves_data),
        .ext_done   (exec_done),
        .take       (take),
        .byte_rdy   (byte_rdy),
        .byte_idx   (byte_idx),
        .done       (exec_fin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            opcode_q <= '0;
            info_q   <= '0;
            cnt_q    <= '0;
            irq_q    <= 1'b0;
            dma_q    <= 1'b0;
        end else begin
            phase_q  <= phase_n;
            opcode_q <= opcode_n;
            info_q   <= info_n;
            cnt_q    <= cnt_n;
            irq_q    <= irq_n;
            dma_q    <= dma_n;
        end
    end

    // Handshake and status outputs (R1, R2, R3, R7, R8)
    always_comb begin
        rqm = 1'b0;
        dio = 1'b0;
        unique case (phase_q)
            PH_IDLE, PH_CMD: rqm = 1'b1;
            PH_EXEC: begin
                if (byte_rdy && !dma_q) begin
                    rqm = 1'b1;
                    dio = info_q.to_host;
                end
            end
            PH_RESULT: begin
                rqm = 1'b1;
                dio = 1'b1;
            end
        endcase
        ndm   = (phase_q == PH_EXEC) && !dma_q;
        busy  = (phase_q != PH_IDLE);
        msr   = {rqm, dio, ndm, busy, seek_busy};
        wr_ok = wr_stb && rqm && !dio;
        rd_ok = rd_stb && rqm && dio;
        take  = (phase_q == PH_EXEC) && byte_rdy &&
                (dma_q ? !dack_n : (info_q.to_host ? rd_ok : wr_ok));
        dreq  = (phase_q == PH_EXEC) && byte_rdy && dma_q;
        irq   = irq_q;
        if (phase_q == PH_RESULT)
            rdata = info_q.invalid ? INVALID_STATUS
                                   : (opcode_q ^ {cnt_q[2:0], 5'b0});
        else if (phase_q == PH_EXEC && rqm && dio)
            rdata = XFER_TAG + byte_idx;
        else
            rdata = 8'h00;
    end

    // Phase sequencing (R4, R5, R9, R10, R11)
    always_comb begin
        phase_n    = phase_q;
        opcode_n   = opcode_q;
        info_n     = info_q;
        cnt_n      = cnt_q;
        irq_n      = irq_q;
        dma_n      = dma_q;
        exec_start = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (wr_ok) begin
                    opcode_n = wdata;
                    info_n   = info_now;
                    dma_n    = dma_mode;
                    cnt_n    = '0;
                    phase_n  = (info_now.n_param == 0) ? after_command(info_now)
                                                       : PH_CMD;
                end
            end
            PH_CMD: begin
                if (wr_ok) begin
                    if (cnt_q == info_q.n_param - 1'b1) begin
                        cnt_n   = '0;
                        phase_n = after_command(info_q);
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            PH_EXEC: begin
                irq_n = !dma_q && byte_rdy && !take;
                if (exec_fin) begin
                    cnt_n = '0;
                    if (info_q.n_result != 0) begin
                        phase_n = PH_RESULT;
                        irq_n   = 1'b1;
                    end else begin
                        phase_n = PH_IDLE;
                        irq_n   = 1'b0;
                    end
                end
            end
            PH_RESULT: begin
                if (rd_ok) begin
                    irq_n = 1'b0;
                    if (cnt_q == CW'(info_q.n_result) - 1'b1) begin
                        cnt_n   = '0;
                        phase_n = PH_IDLE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
        endcase
        if (phase_n == PH_EXEC && phase_q != PH_EXEC)
            exec_start = 1'b1;
    end
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk
    import fdc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic [7:0] msr,
    input logic       dreq,
    input logic       dack_n,
    input logic       irq,
    input phase_e     phase_q,
    input logic [3:0] cnt_q
);
    p_dio_needs_rqm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        msr[6] |-> msr[7]);

    p_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && !(msr[7] && !msr[6]) && phase_q != PH_EXEC)
        |=> (phase_q == $past(phase_q) && cnt_q == $past(cnt_q)));

    p_rd_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !(msr[7] && msr[6]) && phase_q != PH_EXEC)
        |=> (phase_q == $past(phase_q) && cnt_q == $past(cnt_q)));

    p_idle_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !msr[4] |-> (msr[7] && !msr[6] && !msr[5]));

    p_ndm_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msr[5] |-> msr[4]);

    p_dreq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> (!msr[7] && !irq && !msr[5]));

    p_dreq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && !dack_n) |=> !dreq);

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESULT && rd_stb && msr[7] && msr[6]) |=> !irq);
endmodule

bind fdc_host_seq fdc_host_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .msr     (msr),
    .dreq    (dreq),
    .dack_n  (dack_n),
    .irq     (irq),
    .phase_q (phase_q),
    .cnt_q   (cnt_q)
);

// File: tb/fdc_host_seq_test.sv
module fdc_host_seq_test;
    localparam int EXEC_CYCLES = 16;
    localparam int XFER_BYTES  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, msr;
    logic       dma_mode = 1'b0;
    logic       dreq, irq;
    logic       dack_n = 1'b1;
    logic       exec_done = 1'b0;
    logic [3:0] seek_busy = 4'h0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fdc_host_seq #(.EXEC_CYCLES(EXEC_CYCLES), .XFER_BYTES(XFER_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata), .msr(msr), .dma_mode(dma_mode),
        .dreq(dreq), .dack_n(dack_n), .irq(irq), .exec_done(exec_done),
        .seek_busy(seek_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [7:0] b);
        wdata  = b;
        wr_stb = 1'b1;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic pulse_rd(output logic [7:0] v);
        v      = rdata;
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    // Expected table from R4 / R11
    task automatic expect_cmd(input logic [7:0] op, output int np, output int nr,
                              output bit ex, output bit dat, output bit toh, output bit inv);
        np = 0; nr = 1; ex = 0; dat = 0; toh = 0; inv = 1;
        case (op[4:0])
            5'h06: begin np = 8; nr = 7; ex = 1; dat = 1; toh = 1; inv = 0; end
            5'h05: begin np = 8; nr = 7; ex = 1; dat = 1; toh = 0; inv = 0; end
            5'h0F: begin np = 2; nr = 1; ex = 1; inv = 0; end
            5'h03: begin np = 2; nr = 0; inv = 0; end
            5'h04: begin np = 1; nr = 1; inv = 0; end
            5'h08: begin np = 0; nr = 2; inv = 0; end
            default: ;
        endcase
    endtask

    task automatic read_results(input logic [7:0] op, input int nr, input bit inv,
                                input logic [3:0] sk);
        logic [7:0] v, e;
        for (int k = 0; k < nr; k++) begin
            if (k == 0) begin
                pulse_wr(8'hEE);
                check(msr == {4'hD, sk}, "R10 write refused in result", msr, {4'hD, sk});
            end
            pulse_rd(v);
            e = inv ? 8'h80 : (op ^ 8'(k << 5));
            check(v == e, inv ? "R11 invalid status" : "R10 result byte", v, e);
            if (k == 0)
                check(irq == 1'b0, "R9 irq cleared by first read", irq, 0);
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input bit dma);
        int np, nr, waited;
        bit ex, dat, toh, inv, rdy;
        logic [7:0] v;
        logic [3:0] sk;
        expect_cmd(op, np, nr, ex, dat, toh, inv);
        sk = op[3:0] ^ 4'hA;
        seek_busy = sk;
        dma_mode = dma;
        tick();
        check(msr == {4'h8, sk}, "R1 idle status", msr, {4'h8, sk});
        pulse_rd(v);
        check(msr == {4'h8, sk}, "R3 read in idle ignored", msr, {4'h8, sk});
        pulse_wr(op);
        if (np > 0) begin
            check(msr == {4'h9, sk}, "R5 busy in command phase", msr, {4'h9, sk});
            pulse_rd(v);
            check(msr == {4'h9, sk}, "R3 read in command phase ignored", msr, {4'h9, sk});
            for (int i = 0; i < np; i++) begin
                if (i == np - 1)
                    check(msr == {4'h9, sk}, "R4 parameter count", msr, {4'h9, sk});
                pulse_wr(8'(i));
            end
        end
        if (ex) begin
            check(msr[4] == 1'b1 && msr[5] == !dma && msr[7] == 1'b0,
                  "R6 exec entered", msr, {3'b0, !dma, 4'b0});
            waited = 0;
            rdy = dat ? (dma ? dreq : msr[7]) : msr[7];
            while (!rdy && waited < 200) begin
                waited++;
                tick();
                rdy = dat ? (dma ? dreq : msr[7]) : msr[7];
            end
            check(waited == EXEC_CYCLES, "R6 exec delay length", waited, EXEC_CYCLES);
            if (dat) begin
                for (int i = 0; i < XFER_BYTES; i++) begin
                    waited = 0;
                    while (!(dma ? dreq : msr[7]) && waited < 20) begin
                        waited++;
                        tick();
                    end
                    if (!dma) begin
                        tick();
                        check(irq == 1'b1, "R7 per-byte irq", irq, 1);
                        check(msr == {1'b1, toh, 2'b11, sk}, "R7 byte-ready status",
                              msr, {1'b1, toh, 2'b11, sk});
                        if (toh) begin
                            pulse_wr(8'h55);
                            check(irq == 1'b1 && msr[7], "R2 wrong-direction write ignored", irq, 1);
                            pulse_rd(v);
                            check(v == 8'hD0 + 8'(i), "R7 transfer byte value", v, 8'hD0 + i);
                        end else begin
                            pulse_rd(v);
                            check(irq == 1'b1 && msr[7], "R3 wrong-direction read ignored", irq, 1);
                            pulse_wr(8'(i));
                        end
                        if (i < XFER_BYTES - 1)
                            check(irq == 1'b0 && !msr[7], "R7 access clears irq", irq, 0);
                    end else begin
                        check(irq == 1'b0 && !msr[7] && !msr[5], "R8 DMA quiet status", msr, {4'h1, sk});
                        dack_n = 1'b0;
                        tick();
                        dack_n = 1'b1;
                        if (i < XFER_BYTES - 1)
                            check(dreq == 1'b0, "R8 dreq drops after ack", dreq, 0);
                    end
                end
            end
            check(irq == 1'b1, "R9 irq at result start", irq, 1);
            check(msr == {4'hD, sk}, "R9 result status", msr, {4'hD, sk});
        end else if (nr > 0) begin
            check(irq == 1'b0, "R9 no irq without exec", irq, 0);
            check(msr == {4'hD, sk}, inv ? "R11 result status" : "R4 result status",
                  msr, {4'hD, sk});
        end
        read_results(op, nr, inv, sk);
        check(msr == {4'h8, sk}, "R10 back to idle", msr, {4'h8, sk});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        seek_busy = 4'h5;
        repeat (3) tick();
        check(msr == 8'h85 && !irq && !dreq, "R1 reset status", msr, 8'h85);
        rst_n = 1'b1;
        tick();
        // R6: early completion through exec_done on a seek
        seek_busy = 4'h0;
        dma_mode  = 1'b0;
        pulse_wr(8'h0F);
        pulse_wr(8'h00);
        pulse_wr(8'h01);
        tick();
        tick();
        exec_done = 1'b1;
        tick();
        exec_done = 1'b0;
        check(msr[7] && msr[6] && irq, "R6 exec_done ends delay early", msr, 8'hD0);
        pulse_rd(v);
        check(v == 8'h0F, "R10 seek result", v, 8'h0F);
        // Sweep every opcode in both transfer modes
        for (int m = 0; m < 2; m++)
            for (int op = 0; op < 256; op++)
                run_cmd(8'(op), m[0]);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule